// File: doc/BRIEF.md
# Receive Buffer Resource Manager

This block is the receive-side buffer bookkeeping engine of a packet DMA controller. Software keeps a circular ring of resource entries in memory. Each entry gives the start address and the size in words of one receive buffer. The engine takes entries from that ring to hand buffer space to incoming packets. After each packet it records a six-word status record in a linked list of receive descriptors. It then reads the descriptor's link word to find where the next record goes.

One buffer can hold several packets in a row. After each packet the engine compares the space left against a software threshold. While enough space remains, the next packet starts right behind the previous one. Once the space drops below the threshold, a fresh buffer is pulled from the ring. Three separate stall conditions are flagged, and each one needs host action: the ring runs dry, the descriptor list ends, or a packet is longer than the space left in its buffer.

All memory traffic goes through a 16-bit word port with a request/grant handshake. One grant serves one memory area only.

Top module: `rbm_top`

## Requirements
- R1: While reset is held, `ready`, `memReq` and all three flags are low. The first access after reset reads the ring entry at `{ringUpper, ringStart}`.
- R2: Every requested address is even (word aligned). Ring addresses are `{ringUpper, offset}`. An entry is read as four words at +0, +2, +4 and +6, in this order: buffer address low half, buffer address high half, word count low half, word count high half.
- R3: After a fetch, the ring offset moves on by 8 bytes and wraps from `ringEnd` to `ringStart`. When the offset equals `ringWrite`, the ring is empty: `bufExhausted` is set and `ready` stays low. A `retry` pulse tests the ring again. The flag clears when a fetch completes.
- R4: A packet accepted while `ready` is high causes exactly six word writes, at descriptor offsets +0 to +10 in ascending order. The words are: status, length in words, packet start address low half, packet start address high half, sequence number, and zero.
- R5: After the six writes, the word at descriptor offset +12 is read. When its bit 0 is 0, the next descriptor is `{descUpper, link}`.
- R6: When the link word has bit 0 set, `descExhausted` is set and `ready` stays low. Each `retry` reads the link again. The flag clears when a link with bit 0 clear is read.
- R7: An accepted packet of N words moves `bufAddr` on by 2N and reduces `bufLeft` by N. A new ring entry is fetched when `bufLeft` is below `eobWords`. When `bufLeft` equals `eobWords`, the buffer is kept.
- R8: A packet longer than `bufLeft` sets `limitExceeded`. Such a packet causes no memory write and does not advance the sequence number. A `retry` pulse clears the flag.
- R9: Request stays high, with a stable address, until it is granted. It drops for at least one cycle before the engine moves to a different memory area.
- R10: `pktDone` has no effect while `ready` is low.
- R11: The sequence number written in a record counts accepted packets, starting at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringUpper | input | 16 | Upper address half of the resource ring |
| ringStart | input | 16 | First entry offset of the ring |
| ringEnd | input | 16 | Offset one past the last ring entry |
| ringWrite | input | 16 | Host fill offset; ring empty when reached |
| descUpper | input | 16 | Upper address half of the descriptor list |
| descStart | input | 16 | Offset of the first descriptor |
| eobWords | input | 16 | Space threshold in words for buffer reuse |
| pktDone | input | 1 | One-cycle pulse: a packet has ended |
| pktWords | input | 16 | Length of the ended packet in words |
| pktStatus | input | 16 | Status word of the ended packet |
| retry | input | 1 | Host pulse: re-attempt a stall, clear limit flag |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memGnt | input | 1 | Access completes in this cycle |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, valid with grant |
| ready | output | 1 | A buffer is held and a packet may end |
| bufAddr | output | 32 | Address where the next packet starts |
| bufLeft | output | 32 | Words left in the current buffer |
| descExhausted | output | 1 | Descriptor list ended |
| bufExhausted | output | 1 | Resource ring empty |
| limitExceeded | output | 1 | Packet longer than remaining space |

## Verification
Two things can happen in the same step of the ring fetch. The last word of an entry moves the ring offset past `ringEnd` and wraps it to `ringStart`, and the new offset is what the emptiness test compares with `ringWrite`. The test provokes this by placing the host fill offset at `ringStart` just before the engine consumes the final entry. It then checks that the next buffer request stalls on an empty ring, and that after the host refills entry zero the following fetch reads from the ring's first address. The bench also checks a packet ending while the engine is stalled, and a packet that leaves exactly the threshold in the buffer.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {AREA_NONE, AREA_RING, AREA_DESC} area_e;

  typedef struct packed {
    logic       init;    // load start pointers
    logic       ldWord;  // capture a ring word (idx selects)
    logic       accept;  // take the ending packet
    logic       ldLink;  // follow the link word
    area_e      area;
    logic [2:0] idx;
  } ctrlStrobe_t;
endpackage

// File: rtl/rbm_dp.sv
module rbm_dp
  import rbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [WORD_W-1:0] ringUpper,
  input  logic [WORD_W-1:0] ringStart,
  input  logic [WORD_W-1:0] ringEnd,
  input  logic [WORD_W-1:0] ringWrite,
  input  logic [WORD_W-1:0] descUpper,
  input  logic [WORD_W-1:0] descStart,
  input  logic [WORD_W-1:0] eobWords,
  input  logic [WORD_W-1:0] pktWords,
  input  logic [WORD_W-1:0] pktStatus,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [ADDR_W-1:0] bufLeft,
  output logic              ringEmpty,
  output logic              needBuf,
  output logic              pktFits
);
  localparam int BYTES      = WORD_W / 8;
  localparam int RES_STRIDE = 4 * BYTES;

  logic [WORD_W-1:0] ringRd, ringNext;
  logic [ADDR_W-1:0] curDesc, pktPtr;
  logic [WORD_W-1:0] capStatus, capLen, seqCnt, capSeq;
  logic [WORD_W-1:0] stgPtrLo, stgPtrHi, stgCntLo;
  logic [ADDR_W-1:0] idxOff;

  assign ringNext  = (ringRd + WORD_W'(RES_STRIDE) == ringEnd) ? ringStart
                                                               : ringRd + WORD_W'(RES_STRIDE);
  assign ringEmpty = (ringRd == ringWrite);
  assign needBuf   = bufLeft < ADDR_W'(eobWords);
  assign pktFits   = ADDR_W'(pktWords) <= bufLeft;
  assign idxOff    = ADDR_W'(stb.idx) * ADDR_W'(BYTES);

  always_comb begin
    case (stb.area)
      AREA_RING: memAddr = {ringUpper, ringRd} + idxOff;
      AREA_DESC: memAddr = curDesc + idxOff;
      default:   memAddr = curDesc;
    endcase
    case (stb.idx)
      3'd0:    memWdata = capStatus;
      3'd1:    memWdata = capLen;
      3'd2:    memWdata = pktPtr[WORD_W-1:0];
      3'd3:    memWdata = pktPtr[ADDR_W-1:WORD_W];
      3'd4:    memWdata = capSeq;
      default: memWdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringRd <= '0; curDesc <= '0; pktPtr <= '0; bufAddr <= '0; bufLeft <= '0;
      capStatus <= '0; capLen <= '0; seqCnt <= '0; capSeq <= '0;
      stgPtrLo <= '0; stgPtrHi <= '0; stgCntLo <= '0;
    end else begin
      if (stb.init) begin
        ringRd  <= ringStart;
        curDesc <= {descUpper, descStart};
        bufLeft <= '0;
      end
      if (stb.ldWord) begin
        case (stb.idx)
          3'd0: stgPtrLo <= memRdata;
          3'd1: stgPtrHi <= memRdata;
          3'd2: stgCntLo <= memRdata;
          default: begin
            bufAddr <= {stgPtrHi, stgPtrLo};
            bufLeft <= {memRdata, stgCntLo};
            ringRd  <= ringNext;
          end
        endcase
      end
      if (stb.accept) begin
        pktPtr    <= bufAddr;
        bufAddr   <= bufAddr + ADDR_W'(pktWords) * ADDR_W'(BYTES);
        bufLeft   <= bufLeft - ADDR_W'(pktWords);
        capStatus <= pktStatus;
        capLen    <= pktWords;
        capSeq    <= seqCnt;
        seqCnt    <= seqCnt + 1'b1;
      end
      if (stb.ldLink) curDesc <= {descUpper, memRdata};
    end
  end

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[0] == 1'b0); // R2
endmodule

// File: rtl/rbm_ctrl.sv
module rbm_ctrl
  import rbm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        memGnt,
  input  logic        linkEnd,
  input  logic        ringEmpty,
  input  logic        needBuf,
  input  logic        pktFits,
  input  logic        pktDone,
  input  logic        retry,
  output logic        memReq,
  output logic        memWe,
  output logic        ready,
  output logic        descExh,
  output logic        bufExh,
  output logic        limitExc,
  output ctrlStrobe_t stb
);
  typedef enum logic [2:0] {S_INIT, S_CHK, S_RING, S_IDLE, S_DESC, S_GAP, S_DWAIT, S_BWAIT} state_e;

  state_e     state, nState;
  logic [2:0] idx, nIdx;
  logic       setBuf, clrBuf, setDesc, clrDesc, setLim;

  always_comb begin
    nState = state; nIdx = idx;
    setBuf = 1'b0; clrBuf = 1'b0; setDesc = 1'b0; clrDesc = 1'b0; setLim = 1'b0;
    stb = '0; stb.idx = idx;
    memReq = 1'b0; memWe = 1'b0;
    ready = (state == S_IDLE);
    case (state)
      S_INIT: begin stb.init = 1'b1; nState = S_CHK; end
      S_CHK: begin
        nIdx = '0;
        if (ringEmpty) begin setBuf = 1'b1; nState = S_BWAIT; end
        else nState = S_RING;
      end
      S_RING: begin
        memReq = 1'b1; stb.area = AREA_RING;
        if (memGnt) begin
          stb.ldWord = 1'b1; nIdx = idx + 1'b1;
          if (idx == 3'd3) begin clrBuf = 1'b1; nState = S_IDLE; end
        end
      end
      S_IDLE: if (pktDone) begin
        if (pktFits) begin stb.accept = 1'b1; nIdx = '0; nState = S_DESC; end
        else setLim = 1'b1;
      end
      S_DESC: begin
        memReq = 1'b1; stb.area = AREA_DESC; memWe = (idx != 3'd6);
        if (memGnt) begin
          if (idx != 3'd6) nIdx = idx + 1'b1;
          else if (linkEnd) begin setDesc = 1'b1; nState = S_DWAIT; end
          else begin stb.ldLink = 1'b1; clrDesc = 1'b1; nState = S_GAP; end
        end
      end
      S_GAP:   nState = needBuf ? S_CHK : S_IDLE;
      S_DWAIT: if (retry) begin nIdx = 3'd6; nState = S_DESC; end
      S_BWAIT: if (retry) nState = S_CHK;
      default: nState = S_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_INIT; idx <= '0;
      descExh <= 1'b0; bufExh <= 1'b0; limitExc <= 1'b0;
    end else begin
      state <= nState; idx <= nIdx;
      if (setBuf) bufExh <= 1'b1; else if (clrBuf) bufExh <= 1'b0;
      if (setDesc) descExh <= 1'b1; else if (clrDesc) descExh <= 1'b0;
      if (setLim) limitExc <= 1'b1; else if (retry) limitExc <= 1'b0;
    end
  end

  AST_READY_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !descExh && !bufExh); // R3
  AST_LIMIT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (ready && pktDone && !pktFits) |=> ready && !memReq); // R8
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (ready == 1'b0 && $past(ready) == 1'b0 && pktDone) |=> !stb.accept); // R10
endmodule

// File: rtl/rbm_top.sv
module rbm_top
  import rbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] ringUpper,
  input  logic [WORD_W-1:0] ringStart,
  input  logic [WORD_W-1:0] ringEnd,
  input  logic [WORD_W-1:0] ringWrite,
  input  logic [WORD_W-1:0] descUpper,
  input  logic [WORD_W-1:0] descStart,
  input  logic [WORD_W-1:0] eobWords,
  input  logic              pktDone,
  input  logic [WORD_W-1:0] pktWords,
  input  logic [WORD_W-1:0] pktStatus,
  input  logic              retry,
  output logic              memReq,
  output logic              memWe,
  input  logic              memGnt,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              ready,
  output logic [ADDR_W-1:0] bufAddr,
  output logic [ADDR_W-1:0] bufLeft,
  output logic              descExhausted,
  output logic              bufExhausted,
  output logic              limitExceeded
);
  ctrlStrobe_t stb;
  logic ringEmpty, needBuf, pktFits;

  rbm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .memGnt(memGnt), .linkEnd(memRdata[0]),
    .ringEmpty(ringEmpty), .needBuf(needBuf), .pktFits(pktFits),
    .pktDone(pktDone), .retry(retry), .memReq(memReq), .memWe(memWe),
    .ready(ready), .descExh(descExhausted), .bufExh(bufExhausted),
    .limitExc(limitExceeded), .stb(stb)
  );

  rbm_dp #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ringUpper(ringUpper),
    .ringStart(ringStart), .ringEnd(ringEnd), .ringWrite(ringWrite),
    .descUpper(descUpper), .descStart(descStart), .eobWords(eobWords),
    .pktWords(pktWords), .pktStatus(pktStatus), .memRdata(memRdata),
    .memReq(memReq), .memAddr(memAddr), .memWdata(memWdata),
    .bufAddr(bufAddr), .bufLeft(bufLeft), .ringEmpty(ringEmpty),
    .needBuf(needBuf), .pktFits(pktFits)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq && $stable(memAddr) && $stable(memWe)); // R9
  AST_ONE_AREA: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> memAddr[ADDR_W-1:WORD_W] == $past(memAddr[ADDR_W-1:WORD_W])); // R9
endmodule

// File: tb/sim_rbm_top.sv
module sim_rbm_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ringUpper = 16'h0001, ringStart = 16'h0000, ringEnd = 16'h0020;
  logic [15:0] ringWrite = 16'h0018, descUpper = 16'h0002, descStart = 16'h0000;
  logic [15:0] eobWords = 16'd10;
  logic pktDone = 1'b0, retry = 1'b0, memGnt = 1'b0;
  logic [15:0] pktWords = '0, pktStatus = '0, memRdata;
  logic memReq, memWe, ready, descExhausted, bufExhausted, limitExceeded;
  logic [31:0] memAddr, bufAddr, bufLeft;
  logic [15:0] memWdata;

  int checks = 0, failures = 0;
  int descWrites = 0, otherWrites = 0, orderErr = 0, areaErr = 0;
  logic [15:0] ringMem [0:15];
  logic [15:0] descMem [0:127];
  logic [7:0]  lfsr = 8'hA5;
  logic hostWe = 1'b0, hostRing = 1'b0;
  logic [6:0]  hostIdx = '0;
  logic [15:0] hostData = '0;
  logic [31:0] lastWr = '0;
  logic [15:0] lastUpper = '0;
  logic haveLast = 1'b0, sawDrop = 1'b0;

  always #10 clk = ~clk;

  rbm_top u0 (
    .clk(clk), .rstN(rstN), .ringUpper(ringUpper), .ringStart(ringStart),
    .ringEnd(ringEnd), .ringWrite(ringWrite), .descUpper(descUpper),
    .descStart(descStart), .eobWords(eobWords), .pktDone(pktDone),
    .pktWords(pktWords), .pktStatus(pktStatus), .retry(retry),
    .memReq(memReq), .memWe(memWe), .memGnt(memGnt), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .ready(ready),
    .bufAddr(bufAddr), .bufLeft(bufLeft), .descExhausted(descExhausted),
    .bufExhausted(bufExhausted), .limitExceeded(limitExceeded)
  );

  always_comb begin
    if (memAddr[31:16] == 16'h0001)      memRdata = ringMem[memAddr[4:1]];
    else if (memAddr[31:16] == 16'h0002) memRdata = descMem[memAddr[7:1]];
    else                                 memRdata = 16'hBAD0;
  end

  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memGnt <= lfsr[0] | lfsr[2];
  end

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) ringMem[i] <= 16'hEEEE;
      ringMem[0] <= 16'h0000; ringMem[1] <= 16'h0005; ringMem[2] <= 16'd30; ringMem[3] <= 16'h0000;
      ringMem[4] <= 16'h0000; ringMem[5] <= 16'h0006; ringMem[6] <= 16'd12; ringMem[7] <= 16'h0000;
      ringMem[8] <= 16'h0000; ringMem[9] <= 16'h0007; ringMem[10] <= 16'd40; ringMem[11] <= 16'h0000;
      for (int i = 0; i < 128; i++) begin
        if (i % 8 == 6) descMem[i] <= (i / 8 == 3) ? 16'h0041 : 16'((i / 8 + 1) * 16);
        else            descMem[i] <= 16'hDEAD;
      end
    end else begin
      if (hostWe) begin
        if (hostRing) ringMem[hostIdx[3:0]] <= hostData;
        else          descMem[hostIdx] <= hostData;
      end
      if (memReq && memGnt && memWe) begin
        if (memAddr[31:16] == 16'h0002) begin
          descMem[memAddr[7:1]] <= memWdata;
          descWrites <= descWrites + 1;
          if (memAddr[3:0] != 4'h0 && memAddr != lastWr + 32'd2) orderErr <= orderErr + 1;
          lastWr <= memAddr;
        end else otherWrites <= otherWrites + 1;
      end
      if (memReq && memGnt) begin
        if (haveLast && memAddr[31:16] != lastUpper && !sawDrop) areaErr <= areaErr + 1;
        lastUpper <= memAddr[31:16]; haveLast <= 1'b1; sawDrop <= 1'b0;
      end else if (!memReq) sawDrop <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input bit ring, input int idx, input logic [15:0] d);
    @(negedge clk); hostWe = 1'b1; hostRing = ring; hostIdx = 7'(idx); hostData = d;
    @(negedge clk); hostWe = 1'b0;
  endtask

  task automatic pulseRetry();
    @(negedge clk); retry = 1'b1;
    @(negedge clk); retry = 1'b0;
  endtask

  task automatic sendPkt(input int words, input logic [15:0] st);
    @(negedge clk); pktDone = 1'b1; pktWords = 16'(words); pktStatus = st;
    @(negedge clk); pktDone = 1'b0;
  endtask

  task automatic waitFor(input int which, input string tag);
    int n = 0;
    while (n < 2000) begin
      if ((which == 0 && ready) || (which == 1 && descExhausted) || (which == 2 && bufExhausted)) break;
      @(negedge clk); n++;
    end
    chk(n < 2000, tag, n, 0);
  endtask

  task automatic checkDesc(input int off, input int len, input logic [15:0] st,
                           input logic [31:0] ptr, input int seq, input string tag);
    int b = off / 2;
    chk(descMem[b]   == st,              {tag, " status"}, descMem[b], st);
    chk(descMem[b+1] == 16'(len),        {tag, " length"}, descMem[b+1], len);
    chk(descMem[b+2] == ptr[15:0],       {tag, " ptrLo"},  descMem[b+2], ptr[15:0]);
    chk(descMem[b+3] == ptr[31:16],      {tag, " ptrHi"},  descMem[b+3], ptr[31:16]);
    chk(descMem[b+4] == 16'(seq),        {tag, " seq R11"}, descMem[b+4], seq);
    chk(descMem[b+5] == 16'h0000,        {tag, " zero"},   descMem[b+5], 0);
  endtask

  initial begin
    int w0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!ready && !memReq, "R1 reset outputs", {ready, memReq}, 0);
    chk(!descExhausted && !bufExhausted && !limitExceeded, "R1 reset flags",
        {descExhausted, bufExhausted, limitExceeded}, 0);
    rstN = 1'b1;
    while (!memReq) @(negedge clk);
    chk(memAddr == 32'h0001_0000 && !memWe, "R1 first ring read", memAddr, 32'h0001_0000);
    waitFor(0, "R3 first buffer");
    chk(bufAddr == 32'h0005_0000 && bufLeft == 30, "R2 entry decode", bufAddr, 32'h0005_0000);

    sendPkt(8, 16'h1001); waitFor(0, "R4 P1 ready");
    checkDesc(16'h00, 8, 16'h1001, 32'h0005_0000, 0, "R4 P1");
    chk(bufAddr == 32'h0005_0010 && bufLeft == 22, "R7 P1 advance", bufLeft, 22);

    sendPkt(12, 16'h1002); waitFor(0, "R5 P2 ready");
    checkDesc(16'h10, 12, 16'h1002, 32'h0005_0010, 1, "R5 P2 via link");
    chk(bufAddr == 32'h0005_0028 && bufLeft == 10, "R7 equal threshold keeps buffer", bufLeft, 10);

    w0 = descWrites;
    sendPkt(11, 16'h1003); @(negedge clk);
    chk(limitExceeded == 1'b1, "R8 limit flag", limitExceeded, 1);
    chk(ready == 1'b1 && descWrites == w0, "R8 no writes", descWrites, w0);
    chk(descMem[16'h20/2] == 16'hDEAD, "R8 record untouched", descMem[16'h10], 16'hDEAD);
    pulseRetry();
    chk(limitExceeded == 1'b0, "R8 retry clears", limitExceeded, 0);

    sendPkt(10, 16'h1004); waitFor(0, "R7 P4 ready");
    checkDesc(16'h20, 10, 16'h1004, 32'h0005_0028, 2, "R8 P4 seq kept");
    chk(bufAddr == 32'h0006_0000 && bufLeft == 12, "R7 below threshold refetch", bufAddr, 32'h0006_0000);

    sendPkt(4, 16'h1005); waitFor(1, "R6 P5 stall");
    repeat (3) @(negedge clk);
    chk(descExhausted && !ready, "R6 end of list stalls", {descExhausted, ready}, 2'b10);
    checkDesc(16'h30, 4, 16'h1005, 32'h0006_0000, 3, "R6 P5");
    hostWrite(1'b0, 16'h3C / 2, 16'h0040);
    pulseRetry(); waitFor(0, "R6 retry resumes");
    chk(!descExhausted, "R6 flag cleared", descExhausted, 0);
    chk(bufAddr == 32'h0007_0000 && bufLeft == 40, "R2 third entry", bufAddr, 32'h0007_0000);

    sendPkt(35, 16'h1006); waitFor(2, "R3 P6 empty ring");
    checkDesc(16'h40, 35, 16'h1006, 32'h0007_0000, 4, "R5 P6");
    w0 = descWrites;
    sendPkt(5, 16'h1FFF); repeat (4) @(negedge clk);
    chk(descWrites == w0 && !ready && bufExhausted, "R10 pktDone ignored", descWrites, w0);
    hostWrite(1'b1, 12, 16'h0000); hostWrite(1'b1, 13, 16'h0008);
    hostWrite(1'b1, 14, 16'd20);   hostWrite(1'b1, 15, 16'h0000);
    @(negedge clk); ringWrite = 16'h0000;
    pulseRetry(); waitFor(0, "R3 refill");
    chk(!bufExhausted && bufAddr == 32'h0008_0000 && bufLeft == 20, "R3 flag clears", bufAddr, 32'h0008_0000);

    sendPkt(20, 16'h1007); waitFor(2, "R3 wrap meets fill");
    checkDesc(16'h50, 20, 16'h1007, 32'h0008_0000, 5, "R10 P7 seq unaffected");
    hostWrite(1'b1, 0, 16'h0000); hostWrite(1'b1, 1, 16'h0009);
    hostWrite(1'b1, 2, 16'd16);   hostWrite(1'b1, 3, 16'h0000);
    @(negedge clk); ringWrite = 16'h0008;
    pulseRetry(); waitFor(0, "R3 wrapped fetch");
    chk(bufAddr == 32'h0009_0000 && bufLeft == 16, "R3 wrap to ring start", bufAddr, 32'h0009_0000);

    sendPkt(3, 16'h1008); waitFor(0, "R4 P8 ready");
    checkDesc(16'h60, 3, 16'h1008, 32'h0009_0000, 6, "R4 P8");
    chk(bufLeft == 13, "R7 P8 remain", bufLeft, 13);

    @(negedge clk);
    chk(descWrites == 42, "R4 total record writes", descWrites, 42);
    chk(otherWrites == 0, "R4 no stray writes", otherWrites, 0);
    chk(orderErr == 0, "R4 ascending order", orderErr, 0);
    chk(areaErr == 0, "R9 request drop between areas", areaErr, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule